// File: doc/BRIEF.md
# Element-Pointer Short Load Unit

This unit executes the compact 16-bit load instructions. Each one reads memory at an address relative to a base pointer, the general register 30, and that value is supplied on `ep_value`. The unit decodes five short-load forms: a byte load, a halfword load and a word load, plus an unsigned-byte form and an unsigned-halfword form. It scales the small unsigned displacement field by the access size and adds it to the pointer. It issues one memory read and writes the loaded value back, sign- or zero-extended, together with the destination register index taken from the instruction.

A status bit, `ext_swap`, reverses the extension of the byte and halfword loads. When it is clear, the plain forms sign-extend and the unsigned forms zero-extend. When it is set, the plain forms zero-extend and the unsigned forms sign-extend. The value of the bit is taken when the instruction is accepted. The unit handles one load at a time. `insn_ready` is high only while it is idle, and an instruction word that decodes to none of the five forms is dropped.

Top module: `ep_short_load`

## Requirements
- R1: During and right after reset, `insn_ready` is 1 and `mem_req` and `wb_valid` are 0.
- R2: When `insn[10:7]` is `0110`, the word is a byte load. It reads 1 byte (`mem_size`=1) at `ep_value + insn[6:0]`.
- R3: When `insn[10:7]` is `1000`, the word is a halfword load. It reads 2 bytes (`mem_size`=2) at `ep_value + 2*insn[6:0]`.
- R4: When `insn[10:7]` is `1010` and `insn[0]` is 0, the word is a word load. It reads 4 bytes (`mem_size`=4) at `ep_value + 4*insn[6:1]`, and the read data is written back unchanged.
- R5: When `insn[10:4]` is `0000110`, the word is an unsigned byte load that reads 1 byte at `ep_value + insn[3:0]`. When `insn[10:4]` is `0000111`, the word is an unsigned halfword load that reads 2 bytes at `ep_value + 2*insn[3:0]`.
- R6: Some words are ignored: the two unsigned forms when `insn[15:11]` is 0, and every word that matches no form, including `1010` with `insn[0]`=1. For such a word, no read is issued and `insn_ready` stays 1.
- R7: If `ext_swap` was 0 at acceptance, the byte and halfword loads of R2 and R3 sign-extend and those of R5 zero-extend. If it was 1, the two are exchanged. A change of `ext_swap` after acceptance does not affect the load in flight.
- R8: `mem_req` is 1 for exactly one cycle, and that cycle is the one right after the cycle in which the instruction is accepted. `insn_ready` is 0 from acceptance until the write-back cycle has ended.
- R9: `wb_valid` is 1 for exactly one cycle, the cycle after `mem_rvalid` is seen while a read is outstanding, and it carries `wb_idx = insn[15:11]`. A `mem_rvalid` pulse while idle produces no write-back.
- R10: Byte loads use `mem_rdata[7:0]` and halfword loads use `mem_rdata[15:0]`. The higher data bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 16 | Short-load instruction word |
| insn_ready | output | 1 | Unit idle, word taken this cycle |
| ep_value | input | 32 | Base pointer (register 30) |
| ext_swap | input | 1 | Status bit reversing the extension |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_size | output | 3 | Bytes to read: 1, 2 or 4 |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |

## Verification
The bench runs every form with the status bit clear and with it set, using data whose byte and halfword sign bits are 1. A unit that swapped the extension the wrong way, or ignored the status bit, would return a result with wrong upper bits. Maximum displacements check the scaling: a halfword or word displacement scaled by the wrong amount lands at a wrong address, and a word load that treats bit 0 as part of its displacement does too. Ignored encodings are also tried: the unsigned forms with register 0, and a word pattern with bit 0 set. A decoder that accepted them would raise `mem_req`. In another test the status bit flips while a load is outstanding, which exposes a unit that reads the bit late instead of at acceptance. A stray data-valid pulse while idle would produce a false write-back in a unit that did not gate it.

// File: rtl/epsl_pkg.sv
package epsl_pkg;
  localparam int RIDX_W = 5;
  localparam int OFF_W  = 8;

  typedef enum logic [2:0] {
    SZ_B = 3'd1,
    SZ_H = 3'd2,
    SZ_W = 3'd4
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } ld_state_e;

  typedef struct packed {
    logic              hit;
    acc_size_e         size;
    logic              plain;   // plain form: signed unless swapped
    logic [RIDX_W-1:0] rd;
    logic [OFF_W-1:0]  off;     // scaled displacement in bytes
  } ld_dec_t;
endpackage

// File: rtl/epsl_decode.sv
module epsl_decode
  import epsl_pkg::*;
#(
  parameter int ILEN = 16
) (
  input  logic [ILEN-1:0] insn,
  output ld_dec_t         dec
);
  logic [3:0] op_major;
  logic [6:0] op_minor;

  assign op_major = insn[10:7];
  assign op_minor = insn[10:4];

  always_comb begin
    dec       = '0;
    dec.size  = SZ_B;
    dec.rd    = insn[ILEN-1:ILEN-RIDX_W];
    if (op_major == 4'b0110) begin
      dec.hit   = 1'b1;
      dec.size  = SZ_B;
      dec.plain = 1'b1;
      dec.off   = {1'b0, insn[6:0]};
    end else if (op_major == 4'b1000) begin
      dec.hit   = 1'b1;
      dec.size  = SZ_H;
      dec.plain = 1'b1;
      dec.off   = {insn[6:0], 1'b0};
    end else if (op_major == 4'b1010 && !insn[0]) begin
      dec.hit   = 1'b1;
      dec.size  = SZ_W;
      dec.off   = {insn[6:1], 2'b00};
    end else if (op_minor == 7'b0000110 && dec.rd != '0) begin
      dec.hit   = 1'b1;
      dec.size  = SZ_B;
      dec.off   = {4'b0000, insn[3:0]};
    end else if (op_minor == 7'b0000111 && dec.rd != '0) begin
      dec.hit   = 1'b1;
      dec.size  = SZ_H;
      dec.off   = {3'b000, insn[3:0], 1'b0};
    end
  end
endmodule

// File: rtl/epsl_extend.sv
module epsl_extend
  import epsl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] raw,
  input  acc_size_e       size,
  input  logic            sext,
  output logic [XLEN-1:0] ext
);
  always_comb begin
    case (size)
      SZ_B:    ext = {{(XLEN-8){sext & raw[7]}}, raw[7:0]};
      SZ_H:    ext = {{(XLEN-16){sext & raw[15]}}, raw[15:0]};
      default: ext = raw;
    endcase
  end
endmodule

// File: rtl/epsl_fsm.sv
module epsl_fsm
  import epsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rvalid,
  output logic idle,
  output logic req,
  output logic capture,
  output logic done
);
  ld_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start)  st_d = ST_ISSUE;
      ST_ISSUE: st_d = rvalid ? ST_DONE : ST_WAIT;
      ST_WAIT:  if (rvalid) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle    = (st_q == ST_IDLE);
  assign req     = (st_q == ST_ISSUE);
  assign capture = rvalid && (st_q == ST_ISSUE || st_q == ST_WAIT);
  assign done    = (st_q == ST_DONE);

  // R8: request lasts one cycle and follows acceptance
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  p_start_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> req);
  // R9: write-back only after returned data
  p_done_after_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rvalid));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/ep_short_load.sv
module ep_short_load
  import epsl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [ILEN-1:0]   insn,
  output logic              insn_ready,
  input  logic [XLEN-1:0]   ep_value,
  input  logic              ext_swap,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  output logic [2:0]        mem_size,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_rvalid,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  ld_dec_t           dec;
  logic              idle, capture, accept;
  logic [XLEN-1:0]   ext;

  logic [XLEN-1:0]   addr_q, addr_d;
  acc_size_e         size_q, size_d;
  logic              sext_q, sext_d;
  logic [RIDX_W-1:0] rd_q, rd_d;
  logic [XLEN-1:0]   data_q, data_d;

  epsl_decode #(.ILEN(ILEN)) u_dec (.insn(insn), .dec(dec));

  assign accept = insn_valid && idle && dec.hit;

  epsl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .rvalid(mem_rvalid),
    .idle(idle), .req(mem_req), .capture(capture), .done(wb_valid)
  );

  epsl_extend #(.XLEN(XLEN)) u_ext (
    .raw(mem_rdata), .size(size_q), .sext(sext_q), .ext(ext)
  );

  always_comb begin
    addr_d = addr_q;
    size_d = size_q;
    sext_d = sext_q;
    rd_d   = rd_q;
    data_d = data_q;
    if (accept) begin
      addr_d = ep_value + {{(XLEN-OFF_W){1'b0}}, dec.off};
      size_d = dec.size;
      sext_d = dec.plain ^ ext_swap;
      rd_d   = dec.rd;
    end
    if (capture) data_d = ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= SZ_B;
      sext_q <= 1'b0;
      rd_q   <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      size_q <= size_d;
      sext_q <= sext_d;
      rd_q   <= rd_d;
      data_q <= data_d;
    end
  end

  assign insn_ready = idle;
  assign mem_addr   = addr_q;
  assign mem_size   = size_q;
  assign wb_idx     = rd_q;
  assign wb_data    = data_q;

  // R7: zero-extended byte result has clear upper bits
  p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && size_q == SZ_B && !sext_q) |-> (wb_data[XLEN-1:8] == '0));
  // R8: no new acceptance while a load is in flight
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_ready |=> ($stable(wb_idx) && $stable(mem_addr)));
  // R6: a request is only issued for a decoded word
  p_req_from_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(insn_valid && dec.hit));
endmodule

// File: tb/sim_ep_short_load.sv
module sim_ep_short_load;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [15:0] insn;
  logic        insn_ready;
  logic [31:0] ep_value;
  logic        ext_swap;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [2:0]  mem_size;
  logic [31:0] mem_rdata;
  logic        mem_rvalid;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ep_short_load u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .insn_ready(insn_ready), .ep_value(ep_value), .ext_swap(ext_swap),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // kind: 0 byte, 1 half, 2 word, 3 unsigned byte, 4 unsigned half
  typedef struct packed {
    logic [2:0]  kind;
    logic [4:0]  rd;
    logic [6:0]  disp;
    logic [31:0] ep;
    logic        swap;
    logic [31:0] rdata;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 5'd3,  7'h7F, 32'h0000_1000, 1'b0, 32'hDEAD_BE9C, 2'd0},
    '{3'd0, 5'd4,  7'h05, 32'h0000_2000, 1'b1, 32'hDEAD_BE9C, 2'd1},
    '{3'd1, 5'd5,  7'h7F, 32'h1000_0000, 1'b0, 32'h7777_BE9C, 2'd2},
    '{3'd1, 5'd6,  7'h01, 32'h1000_0010, 1'b1, 32'hDEAD_BE9C, 2'd0},
    '{3'd2, 5'd7,  7'h3F, 32'hFFFF_FF00, 1'b0, 32'h8765_4321, 2'd1},
    '{3'd2, 5'd8,  7'h00, 32'h0000_4000, 1'b1, 32'hF000_00F0, 2'd0},
    '{3'd3, 5'd9,  7'h0F, 32'h0000_3000, 1'b0, 32'hDEAD_BE9C, 2'd0},
    '{3'd3, 5'd10, 7'h03, 32'h0000_3100, 1'b1, 32'hDEAD_BE9C, 2'd2},
    '{3'd4, 5'd11, 7'h0F, 32'h0000_5000, 1'b0, 32'hDEAD_BE9C, 2'd1},
    '{3'd4, 5'd31, 7'h02, 32'h0000_5002, 1'b1, 32'hDEAD_BE9C, 2'd0},
    '{3'd0, 5'd1,  7'h00, 32'h0000_6000, 1'b0, 32'h1234_5678, 2'd0},
    '{3'd4, 5'd2,  7'h07, 32'h0000_7000, 1'b1, 32'hFFFF_0081, 2'd1}
  };

  function automatic logic [15:0] make_insn(input logic [2:0] k, input logic [4:0] rd,
                                            input logic [6:0] d);
    case (k)
      3'd0:    return {rd, 4'b0110, d};
      3'd1:    return {rd, 4'b1000, d};
      3'd2:    return {rd, 4'b1010, d[5:0], 1'b0};
      3'd3:    return {rd, 7'b0000110, d[3:0]};
      default: return {rd, 7'b0000111, d[3:0]};
    endcase
  endfunction

  function automatic logic [31:0] exp_off(input logic [2:0] k, input logic [6:0] d);
    case (k)
      3'd0:    return {25'd0, d};
      3'd1:    return {24'd0, d, 1'b0};
      3'd2:    return {24'd0, d[5:0], 2'b00};
      3'd3:    return {28'd0, d[3:0]};
      default: return {27'd0, d[3:0], 1'b0};
    endcase
  endfunction

  function automatic logic [2:0] exp_size(input logic [2:0] k);
    case (k)
      3'd0, 3'd3: return 3'd1;
      3'd1, 3'd4: return 3'd2;
      default:    return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] exp_data(input logic [2:0] k, input logic swap,
                                           input logic [31:0] r);
    logic sgn;
    sgn = ((k == 3'd0) || (k == 3'd1)) ^ swap;
    case (exp_size(k))
      3'd1:    return sgn ? {{24{r[7]}}, r[7:0]}   : {24'd0, r[7:0]};
      3'd2:    return sgn ? {{16{r[15]}}, r[15:0]} : {16'd0, r[15:0]};
      default: return r;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one load through the unit; swap_flip inverts ext_swap after acceptance
  task automatic run_load(input vec_t v, input bit swap_flip);
    logic [31:0] xaddr, xdata;
    xaddr = v.ep + exp_off(v.kind, v.disp);
    xdata = exp_data(v.kind, v.swap, v.rdata);
    @(negedge clk);
    insn       = make_insn(v.kind, v.rd, v.disp);
    ep_value   = v.ep;
    ext_swap   = v.swap;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    if (swap_flip) ext_swap = ~v.swap;
    check(mem_req == 1'b1, "R8", "request after accept", {31'd0, mem_req}, 32'd1);
    check(insn_ready == 1'b0, "R8", "busy after accept", {31'd0, insn_ready}, 32'd0);
    check(mem_addr == xaddr, req_of(v.kind), "address", mem_addr, xaddr);
    check(mem_size == exp_size(v.kind), req_of(v.kind), "size",
          {29'd0, mem_size}, {29'd0, exp_size(v.kind)});
    for (int i = 0; i < int'(v.lat); i++) begin
      @(negedge clk);
      check(mem_req == 1'b0, "R8", "request single cycle", {31'd0, mem_req}, 32'd0);
    end
    mem_rdata  = v.rdata;
    mem_rvalid = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'h0;
    check(wb_valid == 1'b1, "R9", "write-back strobe", {31'd0, wb_valid}, 32'd1);
    check(wb_idx == v.rd, "R9", "write-back index", {27'd0, wb_idx}, {27'd0, v.rd});
    check(wb_data == xdata, (v.kind == 3'd2) ? "R4" : "R7", "write-back data", wb_data, xdata);
    @(negedge clk);
    check(wb_valid == 1'b0, "R9", "strobe single cycle", {31'd0, wb_valid}, 32'd0);
    check(insn_ready == 1'b1, "R8", "ready after write-back", {31'd0, insn_ready}, 32'd1);
  endtask

  task automatic expect_ignored(input logic [15:0] w, input string what);
    @(negedge clk);
    insn       = w;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    check(mem_req == 1'b0, "R6", what, {31'd0, mem_req}, 32'd0);
    check(insn_ready == 1'b1, "R6", what, {31'd0, insn_ready}, 32'd1);
    @(negedge clk);
    check(mem_req == 1'b0, "R6", what, {31'd0, mem_req}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    rst_n      = 1'b0;
    insn_valid = 1'b0;
    insn       = '0;
    ep_value   = '0;
    ext_swap   = 1'b0;
    mem_rdata  = '0;
    mem_rvalid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(insn_ready == 1'b1, "R1", "ready in reset", {31'd0, insn_ready}, 32'd1);
    check(mem_req == 1'b0, "R1", "req in reset", {31'd0, mem_req}, 32'd0);
    check(wb_valid == 1'b0, "R1", "wb in reset", {31'd0, wb_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(insn_ready == 1'b1 && mem_req == 1'b0 && wb_valid == 1'b0, "R1",
          "state after reset", {29'd0, insn_ready, mem_req, wb_valid}, 32'd4);

    // table walk: R2 R3 R4 R5 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) run_load(VECS[k], 1'b0);

    // R6: encodings that must be dropped
    expect_ignored({5'd0, 7'b0000110, 4'hF}, "unsigned byte to r0");
    expect_ignored({5'd0, 7'b0000111, 4'h3}, "unsigned half to r0");
    expect_ignored({5'd9, 4'b1010, 6'h15, 1'b1}, "word pattern with bit0 set");
    expect_ignored({5'd9, 7'b0000000, 4'h1}, "unmatched opcode");

    // R7: status bit changed after acceptance has no effect
    v = '{3'd0, 5'd12, 7'h10, 32'h0000_8000, 1'b0, 32'h0000_0080, 2'd1};
    run_load(v, 1'b1);
    v = '{3'd4, 5'd13, 7'h01, 32'h0000_8000, 1'b1, 32'h0000_8001, 2'd0};
    run_load(v, 1'b1);

    // R10: upper data bits do not leak into byte and halfword results
    v = '{3'd3, 5'd14, 7'h00, 32'h0000_9000, 1'b0, 32'hFFFF_FF01, 2'd0};
    run_load(v, 1'b0);
    v = '{3'd1, 5'd15, 7'h00, 32'h0000_9000, 1'b0, 32'hABCD_7001, 2'd0};
    run_load(v, 1'b0);

    // R9: stray data-valid while idle
    @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(wb_valid == 1'b0, "R9", "no write-back from idle rvalid", {31'd0, wb_valid}, 32'd0);
    @(negedge clk);
    check(wb_valid == 1'b0 && insn_ready == 1'b1, "R9", "idle after stray rvalid",
          {30'd0, wb_valid, insn_ready}, 32'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule